// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block converts a 4-bit BCD digit into drive levels for the seven segments a to g of a numeric readout. A register holds the digit. While the load control is high the register takes the input digit on every clock. While the control is low the register keeps its value, so the readout stays steady while the source bus changes.

Several controls sit between the decoded pattern and the pins:
- A blank control darkens the digit.
- Codes that are not decimal digits darken it automatically.
- A ripple input lets a chain of digits suppress zeros that carry no meaning. A digit holding zero while its ripple input is active goes dark and raises its ripple output for the next digit in the chain.
- A phase input inverts all seven outputs. Driving the phase input and the display backplane with the same square wave gives the antiphase drive that a liquid-crystal readout needs.

The blank, phase and ripple controls act combinationally on the held digit. Only the digit register is clocked.

Top module: `segdec_top`

## Requirements
- R1: On a rising clock edge with `loadEn`=1 and `rst`=0, the held digit takes `digitIn`, and `segOut` shows the new digit right after that edge.
- R2: On a rising edge with `loadEn`=0, the held digit keeps its value, and changes on `digitIn` do not alter `segOut`.
- R3: `segOut` bit 0 is segment a and bit 6 is segment g, active high when `phaseIn`=0. The digits 0 to 9 give 7'h3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F respectively. Digit 6 lights a, and digit 9 lights d.
- R4: A held code from 10 to 15 darkens the digit (all segment bits at their inactive level).
- R5: `blankIn`=1 darkens the digit whatever code is held.
- R6: `phaseIn`=1 inverts all seven bits of `segOut`. The inversion is applied after blanking, so a dark digit reads 7'h7F.
- R7: `rippleOut` is 1 exactly when `rippleIn`=1 and the held digit is 0, and the digit is then dark. `rippleOut` does not depend on `blankIn` or `phaseIn`.
- R8: A synchronous active-high `rst` clears the held digit to 0 and wins over `loadEn`.
- R9: `blankIn`, `phaseIn` and `rippleIn` change `segOut` and `rippleOut` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digitIn | input | 4 | BCD digit to be loaded |
| loadEn | input | 1 | 1: load the digit on each clock; 0: hold it |
| blankIn | input | 1 | 1: darken the digit |
| phaseIn | input | 1 | 1: invert all segment outputs |
| rippleIn | input | 1 | Zero-suppression enable from the previous digit |
| segOut | output | 7 | Segment levels, bit 0 = a to bit 6 = g |
| rippleOut | output | 1 | Zero-suppression enable to the next digit |

## Verification
Some rules hold on every cycle, and the assertions check them:
- the held digit follows the input while loading and stays stable while holding;
- any blanking cause (blank input, an illegal code, or a suppressed ripple zero) leaves all seven outputs equal to the phase level.

Other behaviour only the bench's scenarios can show:
- that each digit gets its exact segment pattern;
- that reset wins over a load;
- that the phase, blank and ripple controls act between clock edges.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int MAX_DIGIT = 9;

  typedef struct packed {
    logic clear;    // reset the held digit
    logic capture;  // load the held digit
    logic blank;    // darken all segments
    logic invert;   // flip output polarity
  } segStrobe_t;

  // bit 0 = a ... bit 6 = g, active high
  function automatic logic [SEG_N-1:0] digitPattern(input logic [DIGIT_W-1:0] code);
    logic [SEG_N-1:0] pat;
    case (code)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = '0;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic       rst,
  input  logic       loadEn,
  input  logic       blankIn,
  input  logic       phaseIn,
  input  logic       rippleIn,
  input  logic       codeZero,
  input  logic       codeIllegal,
  output segStrobe_t strb,
  output logic       rippleOut
);
  logic zeroSuppress;

  always_comb begin
    zeroSuppress  = rippleIn & codeZero;
    strb.clear    = rst;
    strb.capture  = loadEn & ~rst;
    strb.blank    = blankIn | codeIllegal | zeroSuppress;
    strb.invert   = phaseIn;
    rippleOut     = zeroSuppress;
  end
endmodule

// File: rtl/segdec_path.sv
module segdec_path
  import segdec_pkg::*;
#(
  parameter int CODE_W = DIGIT_W,
  parameter int OUT_N  = SEG_N
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] digitIn,
  input  segStrobe_t        strb,
  output logic [OUT_N-1:0]  segOut,
  output logic              codeZero,
  output logic              codeIllegal
);
  localparam logic [CODE_W-1:0] LAST_LEGAL = CODE_W'(MAX_DIGIT);

  logic [CODE_W-1:0] storedCode;
  logic [OUT_N-1:0]  rawSeg;

  always_ff @(posedge clk) begin
    if (strb.clear)        storedCode <= '0;
    else if (strb.capture) storedCode <= digitIn;
  end

  always_comb begin
    rawSeg      = digitPattern(storedCode);
    codeZero    = (storedCode == '0);
    codeIllegal = (storedCode > LAST_LEGAL);
  end

  for (genvar i = 0; i < OUT_N; i++) begin : g_segDrive
    assign segOut[i] = (rawSeg[i] & ~strb.blank) ^ strb.invert;
  end

  // R1: loading takes the input digit
  a_r1_load: assert property (@(posedge clk) disable iff (strb.clear)
    strb.capture |=> storedCode == $past(digitIn));
  // R2: holding keeps the digit
  a_r2_hold: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.capture |=> $stable(storedCode));
endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digitIn,
  input  logic               loadEn,
  input  logic               blankIn,
  input  logic               phaseIn,
  input  logic               rippleIn,
  output logic [SEG_N-1:0]   segOut,
  output logic               rippleOut
);
  segStrobe_t strb;
  logic codeZero;
  logic codeIllegal;

  segdec_ctrl u_ctrl (
    .rst(rst), .loadEn(loadEn), .blankIn(blankIn), .phaseIn(phaseIn),
    .rippleIn(rippleIn), .codeZero(codeZero), .codeIllegal(codeIllegal),
    .strb(strb), .rippleOut(rippleOut)
  );

  segdec_path #(.CODE_W(DIGIT_W), .OUT_N(SEG_N)) u_path (
    .clk(clk), .digitIn(digitIn), .strb(strb), .segOut(segOut),
    .codeZero(codeZero), .codeIllegal(codeIllegal)
  );

  // R4: illegal codes darken the digit
  a_r4_illegal_dark: assert property (@(posedge clk) disable iff (rst)
    codeIllegal |-> segOut == {SEG_N{phaseIn}});
  // R5 and R6: the blank input darkens the digit at the phase level
  a_r5_blank_dark: assert property (@(posedge clk) disable iff (rst)
    blankIn |-> segOut == {SEG_N{phaseIn}});
  // R7: a suppressed zero is dark
  a_r7_ripple_dark: assert property (@(posedge clk) disable iff (rst)
    rippleOut |-> segOut == {SEG_N{phaseIn}});
  // R7: the ripple output needs the ripple input
  a_r7_ripple_needs_in: assert property (@(posedge clk) disable iff (rst)
    rippleOut |-> rippleIn && codeZero);
endmodule

// File: tb/tb_segdec_top.sv
module tb_segdec_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] digitIn = '0;
  logic loadEn = 1'b0, blankIn = 1'b0, phaseIn = 1'b0, rippleIn = 1'b0;
  logic [6:0] segOut;
  logic rippleOut;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  segdec_top dut (
    .clk(clk), .rst(rst), .digitIn(digitIn), .loadEn(loadEn),
    .blankIn(blankIn), .phaseIn(phaseIn), .rippleIn(rippleIn),
    .segOut(segOut), .rippleOut(rippleOut)
  );

  // {load, digit, blank, phase, ripple, expected seg, expected rippleOut}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 4'd0, 3'b000, 7'h3F, 1'b0},  // R3
    {1'b1, 4'd1, 3'b000, 7'h06, 1'b0},
    {1'b1, 4'd2, 3'b000, 7'h5B, 1'b0},
    {1'b1, 4'd3, 3'b000, 7'h4F, 1'b0},
    {1'b1, 4'd4, 3'b000, 7'h66, 1'b0},
    {1'b1, 4'd5, 3'b000, 7'h6D, 1'b0},
    {1'b1, 4'd6, 3'b000, 7'h7D, 1'b0},
    {1'b1, 4'd7, 3'b000, 7'h07, 1'b0},
    {1'b1, 4'd8, 3'b000, 7'h7F, 1'b0},
    {1'b1, 4'd9, 3'b000, 7'h6F, 1'b0},
    {1'b1, 4'd10, 3'b000, 7'h00, 1'b0}, // R4
    {1'b1, 4'd15, 3'b000, 7'h00, 1'b0}, // R4
    {1'b1, 4'd8, 3'b100, 7'h00, 1'b0},  // R5
    {1'b1, 4'd1, 3'b010, 7'h79, 1'b0},  // R6
    {1'b1, 4'd12, 3'b010, 7'h7F, 1'b0}, // R6 illegal under phase
    {1'b1, 4'd3, 3'b110, 7'h7F, 1'b0},  // R6 blank under phase
    {1'b1, 4'd0, 3'b001, 7'h00, 1'b1},  // R7
    {1'b1, 4'd0, 3'b011, 7'h7F, 1'b1},  // R7 with phase
    {1'b1, 4'd5, 3'b001, 7'h6D, 1'b0},  // R7 nonzero
    {1'b1, 4'd0, 3'b101, 7'h00, 1'b1},  // R7 with blank
    {1'b1, 4'd0, 3'b000, 7'h3F, 1'b0},  // R1 reload zero
    {1'b0, 4'd7, 3'b000, 7'h3F, 1'b0},  // R2 hold
    {1'b0, 4'd9, 3'b000, 7'h3F, 1'b0}   // R2 hold
  };

  task automatic check(input string req, input logic [6:0] expSeg, input logic expRo);
    checks++;
    if (segOut !== expSeg || rippleOut !== expRo) begin
      errors++;
      $display("FAIL %s: seg=%h ro=%b expected seg=%h ro=%b", req, segOut, rippleOut, expSeg, expRo);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset state", 7'h3F, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {loadEn, digitIn, blankIn, phaseIn, rippleIn} = VEC[i][15:8];
      @(negedge clk);
      check($sformatf("R1/R3 vector %0d", i), VEC[i][7:1], VEC[i][0]);
    end

    // R9: controls act without a clock edge
    loadEn = 1'b1; digitIn = 4'd4; blankIn = 0; phaseIn = 0; rippleIn = 0;
    @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    phaseIn = 1'b1; #1;
    check("R9 phase combinational", 7'h19, 1'b0);
    phaseIn = 1'b0; blankIn = 1'b1; #1;
    check("R9 blank combinational", 7'h00, 1'b0);
    blankIn = 1'b0; #1;
    check("R2 held digit kept", 7'h66, 1'b0);

    // R7/R9: ripple acts between clock edges on a held zero
    loadEn = 1'b1; digitIn = 4'd0;
    @(negedge clk);
    loadEn = 1'b0;
    rippleIn = 1'b1; #1;
    check("R7 ripple combinational", 7'h00, 1'b1);
    rippleIn = 1'b0; #1;
    check("R7 ripple released", 7'h3F, 1'b0);

    // R8: reset wins over a load
    loadEn = 1'b1; digitIn = 4'd9;
    @(negedge clk);
    check("R1 load nine", 7'h6F, 1'b0);
    rst = 1'b1; digitIn = 4'd6;
    @(negedge clk);
    rst = 1'b0; loadEn = 1'b0;
    check("R8 reset over load", 7'h3F, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule